// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block is the combinational datapath core of a small 8-bit accumulator processor. Each evaluation takes an operation code, a register operand (the accumulator, or the X/Y index register for compare), a memory operand and the current status byte. It returns the 8-bit result, the next status byte and a write-back enable that tells the surrounding core whether the result should be stored. The block holds no state, so its outputs follow its inputs within the same cycle. Instruction decoding, register storage, memory access and decimal arithmetic belong to neighbouring logic.

Every operation writes only the flags it defines and copies the rest from the input status byte. Subtraction treats carry as "no borrow". Bit test copies the two top bits of the memory operand into the flags. The decimal flag is carried through but never changes the arithmetic. Read-modify-write operations (shifts, rotates, increment, decrement) act on the memory operand. An accumulator-form shift is done by presenting the accumulator on that input.

Top module: `alu8_core`

## Requirements
- R1: Status bit positions are fixed: carry bit 0, zero bit 1, interrupt-disable bit 2, decimal bit 3, break bit 4, overflow bit 6, negative bit 7. Bits 2, 3, 4 and 5 of status_o always equal status_i, and a flag an operation does not define equals its input value.
- R2: Op 0 (add with carry) gives result = (reg + mem + C) mod 256 with write-back 1. C is set when the 9-bit sum exceeds 255. V is set when reg and mem share a sign bit and the result sign differs from reg. Z and N come from the result.
- R3: Op 1 (subtract with borrow) gives result = (reg + (255 - mem) + C) mod 256 with write-back 1. C is set when that sum exceeds 255 (no borrow). V is set when reg and mem differ in sign and the result sign differs from reg. Z and N come from the result.
- R4: Op 2 (compare) sets C when reg >= mem, and sets Z and N from (reg - mem) mod 256, which is also the result. V is unchanged and write-back is 0.
- R5: Ops 3, 4 and 5 give reg AND mem, reg OR mem and reg XOR mem with write-back 1. They change only Z and N.
- R6: Op 6 (bit test) sets Z when (reg AND mem) is 0, copies mem bit 7 into N and mem bit 6 into V, and leaves C unchanged. The result equals reg and write-back is 0.
- R7: Op 7 (shift left) and op 9 (rotate left) move mem bit 7 into C. The left shift fills bit 0 with 0 and the left rotate fills it with the old C. Z and N come from the result, V is unchanged and write-back is 1.
- R8: Op 8 (logical shift right) and op 10 (rotate right) move mem bit 0 into C. The logical shift fills bit 7 with 0, so N is always 0, and the right rotate fills it with the old C. Z and N come from the result, V is unchanged and write-back is 1.
- R9: Op 11 (increment) and op 12 (decrement) give (mem + 1) mod 256 and (mem - 1) mod 256 with write-back 1, changing only Z and N.
- R10: Op 13 (load) passes mem to the result with write-back 1 and changes only Z and N.
- R11: Reserved ops 14 and 15 return reg as the result, leave status unchanged and give write-back 0.
- R12: The decimal flag has no effect: add and subtract produce the same result and flags with status bit 3 set as with it clear, apart from bit 3 itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0 to 13 defined, 14 and 15 reserved) |
| reg_i | input | 8 | Register operand: accumulator, or index register for compare |
| mem_i | input | 8 | Memory operand |
| status_i | input | 8 | Current status byte |
| result_o | output | 8 | Operation result |
| status_o | output | 8 | Next status byte |
| wr_en_o | output | 1 | Result should be written back |

## Verification
Carry and overflow are set by the same adder in the same evaluation. The exhaustive sweep of add and subtract over every operand pair, with carry-in 0 and 1, reaches every combination of the two, including both at once (0x80 + 0x80). Against each bench-computed value, it compares the result and also the zero, negative, carry and overflow bits together. Bit test writes zero from the AND of the operands while it copies overflow and negative from the memory operand. Directed cases such as reg 0x0F with mem 0xC0, together with random status bytes, check that all three flags land together. A second sweep with the decimal flag set checks that arithmetic and flag updates run unchanged while bit 3 is carried through.

// File: rtl/alu8_pkg.sv
// Package: shared constants and types for the 8-bit ALU.
// Assumes an 8-bit status byte whose flag positions are fixed by the core.
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int STAT_W = 8;
    localparam int OP_W   = 4;

    // Flag bit positions inside the status byte
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam int FLG_B = 4;
    localparam int FLG_V = 6;
    localparam int FLG_N = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_ORA  = 4'd4,
        OP_EOR  = 4'd5,
        OP_BIT  = 4'd6,
        OP_ASL  = 4'd7,
        OP_LSR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_LD   = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_fn_e;

endpackage

// File: rtl/alu8_addsub.sv
// Module: shared binary adder for add, subtract and compare.
// Subtraction adds the one's complement of b plus the carry-in, so a set
// carry-out means no borrow. Assumes the caller forces cin for compare.
module alu8_addsub #(
    parameter int DATA_W = alu8_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   total;

    // Select true or complemented second operand
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
    end

    // Widened sum with carry-in
    always_comb begin
        total = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_i};
    end

    // Split sum and derive signed overflow from the operand signs
    always_comb begin
        sum_o  = total[DATA_W-1:0];
        cout_o = total[DATA_W];
        ovf_o  = ~(a_i[MSB] ^ b_eff[MSB]) & (a_i[MSB] ^ total[MSB]);
    end

endmodule

// File: rtl/alu8_shift.sv
// Module: one-place shifter and rotator.
// Left moves the top bit out to carry; right moves bit 0 out. The vacated
// position takes the old carry when rotating, zero otherwise.
module alu8_shift #(
    parameter int DATA_W = alu8_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              left_i,
    input  logic              rotate_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] data_o,
    output logic              cout_o
);
    localparam int MSB = DATA_W - 1;

    logic fill;

    // Bit that enters the vacated end
    always_comb begin
        fill = rotate_i & cin_i;
    end

    // Bit that leaves toward carry
    always_comb begin
        cout_o = left_i ? data_i[MSB] : data_i[0];
    end

    // Per-bit neighbour selection
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_lo_end
            assign from_low = fill;
        end else begin : g_lo_mid
            assign from_low = data_i[i-1];
        end
        if (i == MSB) begin : g_hi_end
            assign from_high = fill;
        end else begin : g_hi_mid
            assign from_high = data_i[i+1];
        end
        assign data_o[i] = left_i ? from_low : from_high;
    end

endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise AND / OR / XOR unit, also used for the bit-test mask.
module alu8_logic #(
    parameter int DATA_W = alu8_pkg::DATA_W
) (
    input  alu8_pkg::logic_fn_e fn_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [DATA_W-1:0]   y_o
);
    import alu8_pkg::*;

    // Select the bitwise function
    always_comb begin
        unique case (fn_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            default: y_o = a_i & b_i;
        endcase
    end

endmodule

// File: rtl/alu8_step.sv
// Module: increment / decrement by one with modulo wrap.
module alu8_step #(
    parameter int DATA_W = alu8_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              down_i,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    // Add one or add all-ones (minus one)
    always_comb begin
        data_o = data_i + (down_i ? {DATA_W{1'b1}} : ONE);
    end

endmodule

// File: rtl/alu8_core.sv
// Module: top of the 8-bit ALU. Purely combinational: no clock or reset.
// Routes operands to the sub-units, selects the result, and builds the next
// status byte by overwriting only the flags the chosen operation defines.
// Assumes op_i is stable while its outputs are consumed.
module alu8_core #(
    parameter int DATA_W = alu8_pkg::DATA_W
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] reg_i,
    input  logic [DATA_W-1:0] mem_i,
    input  logic [7:0]        status_i,
    output logic [DATA_W-1:0] result_o,
    output logic [7:0]        status_o,
    output logic              wr_en_o
);
    import alu8_pkg::*;

    localparam int MSB = DATA_W - 1;

    alu_op_e           op;
    logic              c_in;
    logic              as_sub;
    logic              as_cin;
    logic [DATA_W-1:0] as_sum;
    logic              as_cout;
    logic              as_ovf;
    logic_fn_e         lg_fn;
    logic [DATA_W-1:0] lg_y;
    logic              sh_left;
    logic              sh_rot;
    logic [DATA_W-1:0] sh_y;
    logic              sh_cout;
    logic              st_down;
    logic [DATA_W-1:0] st_y;

    logic              upd_c;
    logic              upd_v;
    logic              upd_zn;
    logic              new_c;
    logic              new_v;
    logic              new_z;
    logic              new_n;
    logic [DATA_W-1:0] res;
    logic              wr;

    // Decode the raw op code and current carry
    always_comb begin
        op   = alu_op_e'(op_i);
        c_in = status_i[FLG_C];
    end

    // Adder controls: compare is subtract with carry forced set
    always_comb begin
        as_sub = (op == OP_SBC) || (op == OP_CMP);
        as_cin = (op == OP_CMP) ? 1'b1 : c_in;
    end

    // Logic-unit function; bit test reuses AND
    always_comb begin
        unique case (op)
            OP_ORA:  lg_fn = LG_OR;
            OP_EOR:  lg_fn = LG_XOR;
            default: lg_fn = LG_AND;
        endcase
    end

    // Shifter and step-unit controls
    always_comb begin
        sh_left = (op == OP_ASL) || (op == OP_ROL);
        sh_rot  = (op == OP_ROL) || (op == OP_ROR);
        st_down = (op == OP_DEC);
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i    (reg_i),
        .b_i    (mem_i),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .sum_o  (as_sum),
        .cout_o (as_cout),
        .ovf_o  (as_ovf)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .fn_i (lg_fn),
        .a_i  (reg_i),
        .b_i  (mem_i),
        .y_o  (lg_y)
    );

    alu8_shift #(.DATA_W(DATA_W)) u_shift (
        .data_i   (mem_i),
        .left_i   (sh_left),
        .rotate_i (sh_rot),
        .cin_i    (c_in),
        .data_o   (sh_y),
        .cout_o   (sh_cout)
    );

    alu8_step #(.DATA_W(DATA_W)) u_step (
        .data_i (mem_i),
        .down_i (st_down),
        .data_o (st_y)
    );

    // Result select, write-back and flag update masks per operation
    always_comb begin
        res    = reg_i;
        wr     = 1'b0;
        upd_c  = 1'b0;
        upd_v  = 1'b0;
        upd_zn = 1'b0;
        new_c  = c_in;
        new_v  = status_i[FLG_V];
        unique case (op)
            OP_ADC, OP_SBC: begin
                res    = as_sum;
                wr     = 1'b1;
                upd_c  = 1'b1;
                upd_v  = 1'b1;
                upd_zn = 1'b1;
                new_c  = as_cout;
                new_v  = as_ovf;
            end
            OP_CMP: begin
                res    = as_sum;
                upd_c  = 1'b1;
                upd_zn = 1'b1;
                new_c  = as_cout;
            end
            OP_AND, OP_ORA, OP_EOR: begin
                res    = lg_y;
                wr     = 1'b1;
                upd_zn = 1'b1;
            end
            OP_BIT: begin
                res    = reg_i;
                upd_v  = 1'b1;
                upd_zn = 1'b1;
                new_v  = mem_i[MSB-1];
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                res    = sh_y;
                wr     = 1'b1;
                upd_c  = 1'b1;
                upd_zn = 1'b1;
                new_c  = sh_cout;
            end
            OP_INC, OP_DEC: begin
                res    = st_y;
                wr     = 1'b1;
                upd_zn = 1'b1;
            end
            OP_LD: begin
                res    = mem_i;
                wr     = 1'b1;
                upd_zn = 1'b1;
            end
            default: begin
                res = reg_i;
                wr  = 1'b0;
            end
        endcase
    end

    // Zero and negative sources; bit test takes them from mask and operand
    always_comb begin
        if (op == OP_BIT) begin
            new_z = (lg_y == '0);
            new_n = mem_i[MSB];
        end else begin
            new_z = (res == '0);
            new_n = res[MSB];
        end
    end

    // Assemble next status byte from the input byte and the masks
    always_comb begin
        status_o = status_i;
        if (upd_c) begin
            status_o[FLG_C] = new_c;
        end
        if (upd_v) begin
            status_o[FLG_V] = new_v;
        end
        if (upd_zn) begin
            status_o[FLG_Z] = new_z;
            status_o[FLG_N] = new_n;
        end
    end

    // Drive outputs
    always_comb begin
        result_o = res;
        wr_en_o  = wr;
    end

endmodule

// File: rtl/alu8_chk.sv
// Checker: immediate property checks on the ALU ports, bound into the top.
module alu8_chk #(
    parameter int DATA_W = alu8_pkg::DATA_W
) (
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] reg_i,
    input logic [DATA_W-1:0] mem_i,
    input logic [7:0]        status_i,
    input logic [DATA_W-1:0] result_o,
    input logic [7:0]        status_o,
    input logic              wr_en_o
);
    // Port relations per operation, evaluated whenever inputs settle
    always_comb begin
        // R1
        keep_ctrl_bits_chk: assert (status_o[5:2] == status_i[5:2]);
        if (op_i == 4'd2) begin
            // R4
            cmp_no_write_chk: assert (!wr_en_o && status_o[6] == status_i[6]
                                      && status_o[0] == (reg_i >= mem_i));
        end
        if (op_i == 4'd6) begin
            // R6
            bit_copy_chk: assert (!wr_en_o && result_o == reg_i
                                  && status_o[7] == mem_i[DATA_W-1]
                                  && status_o[6] == mem_i[DATA_W-2]
                                  && status_o[0] == status_i[0]);
        end
        if (op_i == 4'd8) begin
            // R8
            lsr_neg_clear_chk: assert (!status_o[7] && status_o[0] == mem_i[0]);
        end
        if (op_i == 4'd11 || op_i == 4'd12) begin
            // R9
            step_keep_cv_chk: assert (status_o[0] == status_i[0]
                                      && status_o[6] == status_i[6]);
        end
        if (op_i == 4'd14 || op_i == 4'd15) begin
            // R11
            reserved_idle_chk: assert (!wr_en_o && status_o == status_i
                                       && result_o == reg_i);
        end
    end

endmodule

bind alu8_core alu8_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst_n;
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] m;
    logic [7:0] st;
    logic [7:0] res;
    logic [7:0] st_out;
    logic       we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    alu8_core u_dut (
        .op_i     (op),
        .reg_i    (a),
        .mem_i    (m),
        .status_i (st),
        .result_o (res),
        .status_o (st_out),
        .wr_en_o  (we)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: returns {we, status, result}
    function automatic logic [16:0] model(int o, int ra, int mm, logic [7:0] s_in);
        logic [7:0] s;
        int r;
        int t;
        int c;
        logic w;
        s = s_in;
        c = s_in[0];
        w = 1'b1;
        r = ra;
        case (o)
            0: begin
                t = ra + mm + c;
                r = t & 255;
                s[0] = (t > 255);
                s[6] = (((ra ^ mm) & 128) == 0) && (((ra ^ r) & 128) != 0);
            end
            1: begin
                t = ra + (255 - mm) + c;
                r = t & 255;
                s[0] = (t > 255);
                s[6] = (((ra ^ mm) & 128) != 0) && (((ra ^ r) & 128) != 0);
            end
            2: begin
                r = (ra - mm) & 255;
                s[0] = (ra >= mm);
                w = 1'b0;
            end
            3: r = ra & mm;
            4: r = ra | mm;
            5: r = ra ^ mm;
            6: begin
                r = ra;
                w = 1'b0;
            end
            7: begin r = (mm << 1) & 255; s[0] = (mm >= 128); end
            8: begin r = mm >> 1; s[0] = mm & 1; end
            9: begin r = ((mm << 1) | c) & 255; s[0] = (mm >= 128); end
            10: begin r = (mm >> 1) | (c << 7); s[0] = mm & 1; end
            11: r = (mm + 1) & 255;
            12: r = (mm + 255) & 255;
            13: r = mm;
            default: begin r = ra; w = 1'b0; end
        endcase
        if (o == 6) begin
            s[1] = ((ra & mm) == 0);
            s[7] = (mm >= 128);
            s[6] = ((mm & 64) != 0);
        end else if (o <= 13) begin
            s[1] = (r == 0);
            s[7] = (r >= 128);
        end
        return {w, s, r[7:0]};
    endfunction

    function automatic string tag_of(int o);
        case (o)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4, 5: return "R5";
            6: return "R6";
            7, 9: return "R7";
            8, 10: return "R8";
            11, 12: return "R9";
            13: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, int o, int ra, int mm, logic [7:0] s_in);
        logic [16:0] exp;
        exp = model(o, ra, mm, s_in);
        op = o[3:0];
        a  = ra[7:0];
        m  = mm[7:0];
        st = s_in;
        #1;
        n_checks++;
        if ({we, st_out, res} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h m=%02h s=%02h: got we=%b st=%02h res=%02h, exp we=%b st=%02h res=%02h",
                     tag, o, ra, mm, s_in, we, st_out, res, exp[16], exp[15:8], exp[7:0]);
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A1C));
        rst_n = 1'b0;
        op = 4'd0; a = 8'h00; m = 8'h00; st = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero inputs give a zero sum with zero flag (R2)
        check("R2", 0, 0, 0, 8'h00);

        // Directed corners
        check("R2", 0, 8'h80, 8'h80, 8'h00);   // carry and overflow together
        check("R2", 0, 8'h7F, 8'h01, 8'h00);   // positive overflow
        check("R2", 0, 8'hFF, 8'h00, 8'h01);   // carry wraps to zero
        check("R3", 1, 8'h00, 8'h01, 8'h01);   // borrow
        check("R3", 1, 8'h80, 8'h01, 8'h01);   // signed overflow on subtract
        check("R4", 2, 8'h40, 8'h40, 8'h40);   // equal, V kept
        check("R4", 2, 8'h10, 8'h20, 8'h00);   // less than
        check("R6", 6, 8'h0F, 8'hC0, 8'h01);   // Z, N, V at once, C kept
        check("R6", 6, 8'hFF, 8'h01, 8'hC0);
        check("R7", 9, 8'h00, 8'h80, 8'h01);   // rotate left carry in/out
        check("R8", 8, 8'h00, 8'hFF, 8'h80);   // N cleared by logical shift
        check("R8", 10, 8'h00, 8'h01, 8'h01);  // rotate right fills bit 7
        check("R9", 11, 8'h00, 8'hFF, 8'h41);  // increment wraps
        check("R9", 12, 8'h00, 8'h00, 8'h41);  // decrement wraps
        check("R10", 13, 8'h00, 8'h00, 8'hFF);
        check("R11", 14, 8'h5A, 8'hA5, 8'h3C);
        check("R11", 15, 8'hA5, 8'h00, 8'hC3);
        check("R1", 3, 8'hF0, 8'h0F, 8'hFF);   // control bits pass through
        check("R1", 0, 8'h01, 8'h01, 8'h3C);

        // Exhaustive add and subtract, both carry-in values
        for (int o = 0; o < 2; o++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int x = 0; x < 256; x++) begin
                    for (int y = 0; y < 256; y++) begin
                        check(tag_of(o), o, x, y, {7'b0, ci[0]});
                    end
                end
            end
        end

        // Decimal flag set: arithmetic must be unchanged (R12)
        for (int i = 0; i < 4000; i++) begin
            int o;
            o = i & 1;
            check("R12", o, $urandom_range(255), $urandom_range(255),
                  8'h08 | ($urandom_range(255) & 8'hC3));
        end

        // Random mix of all codes with random status
        for (int i = 0; i < 6000; i++) begin
            int o;
            o = $urandom_range(15);
            check(tag_of(o), o, $urandom_range(255), $urandom_range(255),
                  8'($urandom_range(255)));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule